// File: doc/BRIEF.md
# Write-combining line buffer

This block gathers uncached streaming stores into line-sized buffers so they reach the system bus as few, wide transactions. Each store carries an 8-byte-aligned address, eight data bytes and a byte mask. Stores to a line that already has a buffer open are merged into it byte by byte. A store to a new line opens a free buffer. If no buffer is free, the oldest open line is written out first.

A line leaves the block in one of two ways, and the choice depends only on how much of it was written. If every byte was written, the line goes out as a single burst. Otherwise each 8-byte chunk that holds at least one written byte goes out as its own partial write, carrying that chunk's byte enables. A flush request writes out every open line, and a done output reports when no line is held and the bus side is quiet.

The bus port uses a request/ready handshake. Two flags mark the transaction type: burst or partial.

Top module: `wc_line_buffer`

## Requirements
- R1: A store whose line has an open buffer is merged into chunk `wr_addr[5:3]` of that line, and only the bytes whose `wr_mask` bit is set are updated. A later store to the same byte replaces the earlier value. Store addresses are 8-byte aligned.
- R2: A line in which all 64 bytes were written leaves as exactly one transaction. That transaction has `bus_burst`=1, `bus_partial`=0, `bus_addr` = line base (low 6 bits zero) and `bus_be`=8'hFF. Chunk k sits in `bus_data[64k+63:64k]`, with byte lane b of the chunk at bits 8b+7:8b.
- R3: A line with any unwritten byte leaves as one transaction per chunk that holds a written byte. Each of these has `bus_partial`=1 and `bus_burst`=0, the address is line base + 8·k, `bus_be` is that chunk's accumulated mask, and the data is in `bus_data[63:0]`. The transactions are issued in ascending chunk order.
- R4: A store with an all-zero mask is accepted and changes nothing. It opens no buffer and produces no transaction.
- R5: A store to a new line while all `NUM_BUF` buffers are open is held (`wr_ready`=0). The oldest open line is then written out, even if incomplete, and after that the store opens a buffer. Lines are replaced in the order they were opened.
- R6: A `flush_req` pulse writes out every open line, oldest first. No store is accepted until the flush completes.
- R7: `flush_done` is 1 exactly when no line is open, no flush is pending and no bus transaction is in progress. After reset, `flush_done`=1, `bus_req`=0 and `wr_ready`=1.
- R8: A bus transaction completes on a rising edge where both `bus_req` and `bus_ready` are 1. While `bus_req` is 1 and `bus_ready` is 0, the address, enables and data stay stable.
- R9: A line in which every chunk was touched but one byte is missing leaves as eight partial transactions, not as a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Store request present |
| wr_ready | output | 1 | Store accepted on this edge if valid |
| wr_addr | input | ADDR_W | Byte address of the store, 8-byte aligned |
| wr_data | input | 64 | Store data, byte lane b at bits 8b+7:8b |
| wr_mask | input | 8 | Byte mask of the store |
| flush_req | input | 1 | Pulse: write out all open lines |
| flush_done | output | 1 | No line held and bus idle |
| bus_req | output | 1 | Bus transaction request |
| bus_ready | input | 1 | Bus accepts the current transaction |
| bus_addr | output | ADDR_W | Transaction address |
| bus_burst | output | 1 | Full-line burst transaction |
| bus_partial | output | 1 | Single-chunk partial transaction |
| bus_be | output | 8 | Byte enables of a partial transaction |
| bus_data | output | 512 | Line data (burst) or chunk data in low 64 bits |

## Verification
The hardest case to reach is an eviction forced by capacity in the middle of a stream. The replacement order only shows up when more distinct lines are active than there are buffers, and when the evicted line is not the one a naive model would choose. The stimulus first sends a zero-mask store to an unused line, then opens two lines, then stores to a third. A wrong replacement order, or a zero-mask store that wrongly took a buffer, would put the wrong line first in the expected transaction stream. Throughout the test the bus ready signal follows a repeating stall pattern, so that request holding and stability are exercised during every eviction.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
    localparam int CHUNK_BYTES = 8;
    localparam int CHUNK_BITS  = CHUNK_BYTES * 8;
    localparam int CH_W        = $clog2(CHUNK_BYTES);

    typedef logic [CHUNK_BITS-1:0]  chunk_data_t;
    typedef logic [CHUNK_BYTES-1:0] chunk_mask_t;

    typedef enum logic [1:0] {
        D_IDLE  = 2'd0,
        D_BURST = 2'd1,
        D_PART  = 2'd2
    } drain_state_t;

    function automatic int ptr_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/wcb_slot.sv
module wcb_slot
    import wcb_pkg::*;
#(
    parameter int TAG_W  = 26,
    parameter int NCHUNK = 8,
    localparam int IDX_W = (NCHUNK > 1) ? $clog2(NCHUNK) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          alloc,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_chunk,
    input  chunk_data_t                   wr_data,
    input  chunk_mask_t                   wr_mask,
    input  logic [TAG_W-1:0]              tag_in,
    input  logic                          release_i,
    output logic                          open_o,
    output logic [TAG_W-1:0]              tag_o,
    output logic [NCHUNK*CHUNK_BITS-1:0]  line_data,
    output logic [NCHUNK*CHUNK_BYTES-1:0] line_mask
);
    logic [NCHUNK*CHUNK_BYTES-1:0] mask_n;
    logic [NCHUNK*CHUNK_BITS-1:0]  data_n;

    always_comb begin
        mask_n = alloc ? '0 : line_mask;
        data_n = line_data;
        for (int c = 0; c < NCHUNK; c++) begin
            for (int b = 0; b < CHUNK_BYTES; b++) begin
                if (wr_en && (wr_chunk == IDX_W'(c)) && wr_mask[b]) begin
                    mask_n[c*CHUNK_BYTES + b]       = 1'b1;
                    data_n[(c*CHUNK_BYTES + b)*8 +: 8] = wr_data[b*8 +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_o    <= 1'b0;
            tag_o     <= '0;
            line_mask <= '0;
        end else if (release_i) begin
            open_o    <= 1'b0;
            line_mask <= '0;
        end else begin
            if (alloc) begin
                open_o <= 1'b1;
                tag_o  <= tag_in;
            end
            line_mask <= mask_n;
        end
    end

    always_ff @(posedge clk) begin
        line_data <= data_n;
    end

    // R1: a store into a closed slot must come with its allocation
    assert_merge_open_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !alloc) |-> open_o);
endmodule

// File: rtl/wcb_drain.sv
module wcb_drain
    import wcb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NCHUNK = 8,
    localparam int IDX_W = (NCHUNK > 1) ? $clog2(NCHUNK) : 1,
    localparam int OFF_W = IDX_W + CH_W,
    localparam int TAG_W = ADDR_W - OFF_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic [TAG_W-1:0]              tag,
    input  logic [NCHUNK*CHUNK_BITS-1:0]  line_data,
    input  logic [NCHUNK*CHUNK_BYTES-1:0] line_mask,
    output logic                          busy,
    output logic                          done,
    output logic                          bus_req,
    input  logic                          bus_ready,
    output logic [ADDR_W-1:0]             bus_addr,
    output logic                          bus_burst,
    output logic                          bus_partial,
    output chunk_mask_t                   bus_be,
    output logic [NCHUNK*CHUNK_BITS-1:0]  bus_data
);
    drain_state_t      state;
    logic [NCHUNK-1:0] pend;
    logic [NCHUNK-1:0] chunk_any;
    logic [NCHUNK-1:0] cur_oh;
    logic [NCHUNK-1:0] pend_rest;
    logic [IDX_W-1:0]  cur_idx;
    logic              line_full;

    generate
        for (genvar k = 0; k < NCHUNK; k++) begin : g_any
            assign chunk_any[k] = |line_mask[k*CHUNK_BYTES +: CHUNK_BYTES];
        end
    endgenerate

    assign line_full = &line_mask;
    assign cur_oh    = pend & (~pend + NCHUNK'(1));
    assign pend_rest = pend & ~cur_oh;

    always_comb begin
        cur_idx = '0;
        for (int k = 0; k < NCHUNK; k++) begin
            if (cur_oh[k]) cur_idx = IDX_W'(k);
        end
    end

    assign busy        = (state != D_IDLE);
    assign bus_req     = busy;
    assign bus_burst   = (state == D_BURST);
    assign bus_partial = (state == D_PART);
    assign done        = bus_ready && (bus_burst || (bus_partial && (pend_rest == '0)));

    always_comb begin
        if (bus_burst) begin
            bus_addr = {tag, {OFF_W{1'b0}}};
            bus_be   = '1;
            bus_data = line_data;
        end else begin
            bus_addr = {tag, cur_idx, {CH_W{1'b0}}};
            bus_be   = line_mask[cur_idx*CHUNK_BYTES +: CHUNK_BYTES];
            bus_data = '0;
            bus_data[CHUNK_BITS-1:0] = line_data[cur_idx*CHUNK_BITS +: CHUNK_BITS];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= D_IDLE;
            pend  <= '0;
        end else begin
            case (state)
                D_IDLE: if (start) begin
                    if (line_full) state <= D_BURST;
                    else begin
                        state <= D_PART;
                        pend  <= chunk_any;
                    end
                end
                D_BURST: if (bus_ready) state <= D_IDLE;
                D_PART: if (bus_ready) begin
                    pend <= pend_rest;
                    if (pend_rest == '0) state <= D_IDLE;
                end
                default: state <= D_IDLE;
            endcase
        end
    end

    // R8: a waiting transaction keeps its fields
    assert_hold_fields_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_be)
                                     && $stable(bus_data) && $stable(bus_burst)));
    // R2, R3: every request is of exactly one kind
    assert_one_kind_R2: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> $onehot({bus_burst, bus_partial}));
    // R3: partial chunks leave in ascending address order
    assert_ascending_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_ready && bus_partial) |=>
            (!bus_req || (bus_addr > $past(bus_addr))));
    // R3: a partial transaction never carries an empty enable mask
    assert_part_be_R3: assert property (@(posedge clk) disable iff (rst)
        bus_partial |-> (bus_be != '0));
endmodule

// File: rtl/wc_line_buffer.sv
module wc_line_buffer
    import wcb_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int NUM_BUF    = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_valid,
    output logic                  wr_ready,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [63:0]           wr_data,
    input  logic [7:0]            wr_mask,
    input  logic                  flush_req,
    output logic                  flush_done,
    output logic                  bus_req,
    input  logic                  bus_ready,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic                  bus_burst,
    output logic                  bus_partial,
    output logic [7:0]            bus_be,
    output logic [LINE_BYTES*8-1:0] bus_data
);
    localparam int NCHUNK = LINE_BYTES / CHUNK_BYTES;
    localparam int IDX_W  = (NCHUNK > 1) ? $clog2(NCHUNK) : 1;
    localparam int OFF_W  = IDX_W + CH_W;
    localparam int TAG_W  = ADDR_W - OFF_W;
    localparam int PTR_W  = ptr_width(NUM_BUF);
    localparam int CNT_W  = $clog2(NUM_BUF + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(NUM_BUF);

    logic [TAG_W-1:0] wr_tag;
    logic [IDX_W-1:0] wr_chunk;
    assign wr_tag   = wr_addr[ADDR_W-1:OFF_W];
    assign wr_chunk = wr_addr[OFF_W-1:CH_W];

    logic [NUM_BUF-1:0]            slot_open;
    logic [TAG_W-1:0]              slot_tag  [NUM_BUF];
    logic [NCHUNK*CHUNK_BITS-1:0]  slot_data [NUM_BUF];
    logic [NCHUNK*CHUNK_BYTES-1:0] slot_mask [NUM_BUF];
    logic [NUM_BUF-1:0]            hit;
    logic [NUM_BUF-1:0]            slot_we;
    logic [NUM_BUF-1:0]            slot_alloc;
    logic [NUM_BUF-1:0]            slot_rel;

    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             flush_pend;
    logic             drain_busy, drain_done, drain_start;
    logic             mask_nz, hit_any, can_take, accept, alloc, idle;

    generate
        for (genvar i = 0; i < NUM_BUF; i++) begin : g_slot
            assign hit[i]        = slot_open[i] && (slot_tag[i] == wr_tag);
            assign slot_alloc[i] = alloc && (wr_ptr == PTR_W'(i));
            assign slot_we[i]    = accept && (hit[i] || slot_alloc[i]);
            assign slot_rel[i]   = drain_done && (rd_ptr == PTR_W'(i));

            wcb_slot #(.TAG_W(TAG_W), .NCHUNK(NCHUNK)) u_slot (
                .clk       (clk),
                .rst       (rst),
                .alloc     (slot_alloc[i]),
                .wr_en     (slot_we[i]),
                .wr_chunk  (wr_chunk),
                .wr_data   (wr_data),
                .wr_mask   (wr_mask),
                .tag_in    (wr_tag),
                .release_i (slot_rel[i]),
                .open_o    (slot_open[i]),
                .tag_o     (slot_tag[i]),
                .line_data (slot_data[i]),
                .line_mask (slot_mask[i])
            );
        end
    endgenerate

    assign mask_nz  = |wr_mask;
    assign hit_any  = |hit;
    assign can_take = hit_any || (count != FULL_CNT);
    assign idle     = !drain_busy && !flush_pend;
    assign wr_ready = idle && (!mask_nz || can_take);
    assign accept   = wr_valid && wr_ready && mask_nz;
    assign alloc    = accept && !hit_any;

    assign drain_start = !drain_busy && (count != '0) &&
                         (flush_pend || (wr_valid && mask_nz && !hit_any && count == FULL_CNT));
    assign flush_done  = !flush_pend && !drain_busy && (count == '0);

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(NUM_BUF - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr     <= '0;
            rd_ptr     <= '0;
            count      <= '0;
            flush_pend <= 1'b0;
        end else begin
            if (alloc)      wr_ptr <= ptr_next(wr_ptr);
            if (drain_done) rd_ptr <= ptr_next(rd_ptr);
            count <= count + CNT_W'(alloc) - CNT_W'(drain_done);
            if (flush_req)
                flush_pend <= 1'b1;
            else if (!drain_busy && count == '0)
                flush_pend <= 1'b0;
        end
    end

    wcb_drain #(.ADDR_W(ADDR_W), .NCHUNK(NCHUNK)) u_drain (
        .clk         (clk),
        .rst         (rst),
        .start       (drain_start),
        .tag         (slot_tag[rd_ptr]),
        .line_data   (slot_data[rd_ptr]),
        .line_mask   (slot_mask[rd_ptr]),
        .busy        (drain_busy),
        .done        (drain_done),
        .bus_req     (bus_req),
        .bus_ready   (bus_ready),
        .bus_addr    (bus_addr),
        .bus_burst   (bus_burst),
        .bus_partial (bus_partial),
        .bus_be      (bus_be),
        .bus_data    (bus_data)
    );

    // R5: open lines never exceed the buffer count
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT);
    // R5: a finished write-out frees exactly one buffer
    assert_release_R5: assert property (@(posedge clk) disable iff (rst)
        drain_done |=> (count == $past(count) - CNT_W'(1)));
    // R6: a pending flush with open lines starts a write-out next cycle
    assert_flush_starts_R6: assert property (@(posedge clk) disable iff (rst)
        (flush_pend && !drain_busy && count != '0) |=> drain_busy);
    // R1: stores carrying bytes arrive 8-byte aligned
    assert_aligned_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && mask_nz) |-> (wr_addr[CH_W-1:0] == '0));
endmodule

// File: tb/wc_line_buffer_tb.sv
module wc_line_buffer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic         clk = 1'b0;
    logic         rst;
    logic         wr_valid = 1'b0;
    logic         wr_ready;
    logic [31:0]  wr_addr = '0;
    logic [63:0]  wr_data = '0;
    logic [7:0]   wr_mask = '0;
    logic         flush_req = 1'b0;
    logic         flush_done;
    logic         bus_req;
    logic         bus_ready = 1'b0;
    logic [31:0]  bus_addr;
    logic         bus_burst;
    logic         bus_partial;
    logic [7:0]   bus_be;
    logic [511:0] bus_data;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    typedef struct {
        logic [31:0]  addr;
        logic         burst;
        logic [7:0]   be;
        logic [511:0] data;
        string        req;
    } exp_t;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    wc_line_buffer u_dut (
        .clk(clk), .rst(rst),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_mask(wr_mask),
        .flush_req(flush_req), .flush_done(flush_done),
        .bus_req(bus_req), .bus_ready(bus_ready), .bus_addr(bus_addr),
        .bus_burst(bus_burst), .bus_partial(bus_partial),
        .bus_be(bus_be), .bus_data(bus_data)
    );

    task automatic chk(input logic ok, input string req, input logic [511:0] act,
                       input logic [511:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] lane_mask(input logic [7:0] be);
        logic [63:0] m;
        for (int b = 0; b < 8; b++) m[b*8 +: 8] = {8{be[b]}};
        return m;
    endfunction

    function automatic logic [63:0] pat(input logic [7:0] s);
        return 64'h0101010101010101 * 64'(s);
    endfunction

    // Monitor: bus responder with a repeating stall pattern (R8), scoreboard pop
    always begin
        @(negedge clk);
        cyc++;
        bus_ready = ((cyc % 3) != 1);
        #1;
        if (!rst && bus_req && bus_ready) begin
            if (q.size() == 0) begin
                chk(1'b0, "R4 unexpected transaction", {480'd0, bus_addr}, '0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(bus_addr == e.addr, {e.req, " addr"}, {480'd0, bus_addr}, {480'd0, e.addr});
                chk(bus_burst == e.burst && bus_partial == !e.burst, {e.req, " kind"},
                    {510'd0, bus_burst, bus_partial}, {510'd0, e.burst, !e.burst});
                if (e.burst) begin
                    chk(bus_data == e.data, {e.req, " burst data"}, bus_data, e.data);
                end else begin
                    chk(bus_be == e.be, {e.req, " be"}, {504'd0, bus_be}, {504'd0, e.be});
                    chk(((bus_data[63:0] ^ e.data[63:0]) & lane_mask(e.be)) == '0,
                        {e.req, " chunk data"}, bus_data, e.data);
                end
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > WATCHDOG) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
            finish_run();
        end
    end

    task automatic push_part(input logic [31:0] a, input logic [7:0] be,
                             input logic [63:0] d, input string req);
        exp_t e;
        e.addr = a; e.burst = 1'b0; e.be = be; e.data = {448'd0, d}; e.req = req;
        q.push_back(e);
    endtask

    task automatic wr(input logic [31:0] a, input logic [63:0] d, input logic [7:0] m);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_mask = m;
        #1;
        while (!wr_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        wr_valid = 1'b0;
    endtask

    task automatic do_flush(input string req);
        @(negedge clk);
        flush_req = 1'b1;
        @(posedge clk);
        #1;
        flush_req = 1'b0;
        @(negedge clk);
        #2;
        chk(!wr_ready && !flush_done, "R6 stores held during flush",
            {510'd0, wr_ready, flush_done}, '0);
        while (!flush_done) begin
            @(negedge clk);
            #2;
        end
        chk(q.size() == 0, {req, " all transactions seen"}, 512'(q.size()), '0);
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        #2;
        // R7 reset state
        chk(!bus_req && flush_done && wr_ready, "R7 reset state",
            {509'd0, bus_req, flush_done, wr_ready}, {509'd0, 3'b011});

        // R2: fully written line -> one burst
        begin
            logic [511:0] line;
            exp_t e;
            for (int c = 0; c < 8; c++) begin
                line[c*64 +: 64] = pat(8'(8'h10 + c));
                wr(32'h0000_1000 + 32'(c*8), pat(8'(8'h10 + c)), 8'hFF);
            end
            @(negedge clk);
            #2;
            chk(!flush_done, "R7 done low with open line", {511'd0, flush_done}, '0);
            e.addr = 32'h0000_1000; e.burst = 1'b1; e.be = 8'hFF; e.data = line; e.req = "R2";
            q.push_back(e);
            do_flush("R2");
        end

        // R3: chunks 5,1,3 written out of order -> partials ascending
        wr(32'h0000_2068, pat(8'h55), 8'hF0);
        wr(32'h0000_2048, pat(8'h11), 8'hFF);
        wr(32'h0000_2058, pat(8'h33), 8'h0F);
        push_part(32'h0000_2048, 8'hFF, pat(8'h11), "R3");
        push_part(32'h0000_2058, 8'h0F, pat(8'h33), "R3");
        push_part(32'h0000_2068, 8'hF0, pat(8'h55), "R3");
        do_flush("R3");

        // R1: byte-mask merge, later store wins
        wr(32'h0000_3010, 64'h1111_1111_1111_1111, 8'h0F);
        wr(32'h0000_3010, 64'h2222_2222_2222_2222, 8'h3C);
        push_part(32'h0000_3010, 8'h3F, 64'h0000_2222_2222_1111, "R1");
        do_flush("R1");

        // R4 + R5: zero-mask store opens nothing; third line evicts the oldest
        wr(32'h0000_6000, pat(8'h66), 8'h00);
        wr(32'h0000_7000, pat(8'h77), 8'hFF);
        wr(32'h0000_8010, pat(8'h88), 8'hFF);
        push_part(32'h0000_7000, 8'hFF, pat(8'h77), "R5 oldest evicted (R4 no slot)");
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = 32'h0000_9038; wr_data = pat(8'h99); wr_mask = 8'hFF;
        #1;
        chk(!wr_ready, "R5 new line held while full", {511'd0, wr_ready}, '0);
        wr(32'h0000_9038, pat(8'h99), 8'hFF);
        // R6: flush writes remaining lines oldest first
        push_part(32'h0000_8010, 8'hFF, pat(8'h88), "R6 order");
        push_part(32'h0000_9038, 8'hFF, pat(8'h99), "R6 order");
        do_flush("R6");

        // R9: every chunk touched, one byte missing -> eight partials
        for (int c = 0; c < 8; c++) begin
            logic [7:0] m;
            m = (c == 4) ? 8'h7F : 8'hFF;
            wr(32'h0000_A000 + 32'(c*8), pat(8'(8'hA0 + c)), m);
            push_part(32'h0000_A000 + 32'(c*8), m, pat(8'(8'hA0 + c)), "R9");
        end
        do_flush("R9");

        // R7: empty flush completes with nothing on the bus
        do_flush("R7 empty flush");
        @(negedge clk);
        #2;
        chk(flush_done && !bus_req, "R7 idle after flush",
            {510'd0, flush_done, bus_req}, {510'd0, 2'b10});

        finish_run();
    end
endmodule